// File: doc/BRIEF.md
# Multi-Packet Message Reassembler

This block rebuilds one message from a run of packets that a header checker has already validated. Each packet opens with a header beat that carries two 8-bit fields: how many packets the whole message has, and the position of this packet within it. The packet's payload bytes follow one per cycle, and an end marker closes the packet. The reassembler writes every accepted byte into a message buffer through a simple write port. Addresses run on without a gap from packet to packet, so the buffer holds the message in packet order.

When the packet whose number equals the total count closes, the block raises a one-cycle completion pulse together with the byte length of the whole message. A packet may carry no payload at all. A packet may carry at most 80 bytes, so with up to 255 packets a message is at most 20,400 bytes long. Broken sequences abort the partial message and raise one of three error pulses: sequence, total mismatch or overflow. A fresh packet numbered 1 always starts a new message.

Top module: `msg_reassembler`

## Requirements
- R1: While reset is high and in the first cycle after it, the signals wr_en, msg_done, err_seq, err_total and err_ovf are all low.
- R2: Each payload byte of packet 1 is written one cycle after it is presented. The write puts pld_data on wr_data, and the address starts at 0 and rises by one for each byte.
- R3: Each byte of a later packet is written at the address that follows the last byte of the packet before it, so the buffer holds the message in packet order.
- R4: One cycle after the end marker of the packet whose number equals the total count, msg_done pulses for one cycle and msg_len gives the byte count of the whole message. If the final byte and the end marker share a cycle, the write and the completion appear in the same cycle.
- R5: A packet with no payload bytes is accepted, adds zero to the length, and can complete a message of length 0.
- R6: A packet number that is 0, that is neither 1 nor one more than the last accepted number, or that arrives with no message in progress raises err_seq one cycle after the header. It also drops the partial message.
- R7: A total count that differs from the count in packet 1 of the message raises err_total and drops the partial message. A packet numbered 1 with a total count of 0 also raises err_total.
- R8: Packets of 80 bytes are accepted. An 81st byte in one packet raises err_ovf one cycle later and is not written. The message is dropped, and the end marker in that cycle has no effect.
- R9: A header numbered 1 with a nonzero total, arriving while a message is in progress, drops the partial message without an error. Writes start again at address 0, and the final length counts only the new message.
- R10: Payload bytes and end markers that arrive outside an accepted packet produce no write and no completion.
- R11: msg_done, err_seq, err_total and err_ovf are never high in the same cycle, and each event gives a single one-cycle pulse.
- R12: A message of 255 packets of 80 bytes each completes with msg_len equal to 20400 and last address 20399.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hdr_valid | input | 1 | Header beat of a new packet |
| hdr_total | input | 8 | Number of packets in the message |
| hdr_num | input | 8 | Position of this packet, counted from 1 |
| pld_valid | input | 1 | Payload byte present |
| pld_data | input | 8 | Payload byte |
| pkt_end | input | 1 | End of packet; may share a cycle with the last byte |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | 15 | Buffer byte address |
| wr_data | output | 8 | Buffer write data |
| msg_done | output | 1 | Message complete pulse |
| msg_len | output | 15 | Message length in bytes, valid with msg_done |
| err_seq | output | 1 | Sequence error pulse |
| err_total | output | 1 | Total count mismatch pulse |
| err_ovf | output | 1 | Payload overflow pulse |

## Verification
Two pairs of functions can fall in the same cycle. The first is overflow detection and packet close. The bench sends an 81st byte with the end marker in the same cycle and expects only err_ovf, with no write and no completion. The second is the final byte write and message completion. Packets whose last byte carries the end marker must produce the write strobe and msg_done together. A scoreboard pairs every strobe and pulse with the item the bench model predicted, and any output that nothing predicted is reported as a failure.

// File: rtl/msg_rasm_pkg.sv
package msg_rasm_pkg;

    localparam int unsigned NUM_W    = 8;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned MAX_PLD  = 80;
    localparam int unsigned MAX_PKTS = (1 << NUM_W) - 1;
    localparam int unsigned MAX_MSG  = MAX_PLD * MAX_PKTS;
    localparam int unsigned MSG_W    = $clog2(MAX_MSG + 1);
    localparam int unsigned PC_W     = $clog2(MAX_PLD + 1);

    typedef logic [NUM_W-1:0]  pnum_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [MSG_W-1:0]  mlen_t;
    typedef logic [PC_W-1:0]   pcnt_t;

    typedef enum logic [2:0] {
        HV_NONE,
        HV_START,
        HV_NEXT,
        HV_ERR_SEQ,
        HV_ERR_TOT
    } hdr_verdict_e;

    typedef struct packed {
        logic  en;
        mlen_t addr;
        byte_t data;
    } wr_beat_t;

    typedef struct packed {
        logic done;
        logic seq;
        logic tot;
        logic ovf;
    } evt_t;

    function automatic hdr_verdict_e judge_header(
        input logic  valid,
        input logic  active,
        input pnum_t num,
        input pnum_t total,
        input pnum_t cur,
        input pnum_t total_r
    );
        logic [NUM_W:0] want;
        want = {1'b0, cur} + (NUM_W+1)'(1);
        if (!valid)
            return HV_NONE;
        if (num == pnum_t'(1))
            return (total == '0) ? HV_ERR_TOT : HV_START;
        if (!active || ({1'b0, num} != want))
            return HV_ERR_SEQ;
        if (total != total_r)
            return HV_ERR_TOT;
        return HV_NEXT;
    endfunction

endpackage

// File: rtl/msg_rasm_seq.sv
module msg_rasm_seq
    import msg_rasm_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         hdr_valid,
    input  pnum_t        hdr_total,
    input  pnum_t        hdr_num,
    input  logic         pkt_close,
    input  logic         ovf_abort,
    output hdr_verdict_e verdict,
    output logic         last_pkt
);

    logic  active;
    pnum_t total_r;
    pnum_t cur_r;

    always_comb begin
        verdict  = judge_header(hdr_valid, active, hdr_num, hdr_total, cur_r, total_r);
        last_pkt = (cur_r == total_r);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            total_r <= '0;
            cur_r   <= '0;
        end else begin
            unique case (verdict)
                HV_START: begin
                    active  <= 1'b1;
                    total_r <= hdr_total;
                    cur_r   <= pnum_t'(1);
                end
                HV_NEXT:    cur_r  <= hdr_num;
                HV_ERR_SEQ: active <= 1'b0;
                HV_ERR_TOT: active <= 1'b0;
                default: begin
                    if (ovf_abort)
                        active <= 1'b0;
                    else if (pkt_close && last_pkt)
                        active <= 1'b0;
                end
            endcase
        end
    end

    // R9: a packet numbered 1 opens a fresh message at position 1
    a_r9_start_opens: assert property (@(posedge clk) disable iff (rst)
        (verdict == HV_START) |=> (active && cur_r == pnum_t'(1)));

    // R6: a sequence fault leaves no message open
    a_r6_seq_closes: assert property (@(posedge clk) disable iff (rst)
        (verdict == HV_ERR_SEQ) |=> !active);

    // R7: a total mismatch leaves no message open
    a_r7_tot_closes: assert property (@(posedge clk) disable iff (rst)
        (verdict == HV_ERR_TOT) |=> !active);

    // R3: an accepted follow-on packet advances the position by exactly one
    a_r3_pos_step: assert property (@(posedge clk) disable iff (rst)
        (verdict == HV_NEXT) |=> (cur_r == $past(cur_r) + pnum_t'(1)));

endmodule

// File: rtl/msg_rasm_wr.sv
module msg_rasm_wr
    import msg_rasm_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  hdr_verdict_e verdict,
    input  logic         pld_valid,
    input  byte_t        pld_data,
    input  logic         pkt_end,
    output wr_beat_t     wr,
    output logic         ovf_abort,
    output logic         pkt_close,
    output mlen_t        close_len
);

    logic  in_pkt;
    pcnt_t cnt;
    mlen_t base;
    logic  take;
    logic  full;
    logic  wr_go;
    logic  hdr_idle;

    always_comb begin
        hdr_idle  = (verdict == HV_NONE);
        take      = in_pkt && pld_valid && hdr_idle;
        full      = (cnt == pcnt_t'(MAX_PLD));
        ovf_abort = take && full;
        wr_go     = take && !full;
        pkt_close = in_pkt && pkt_end && hdr_idle && !ovf_abort;
        close_len = base + mlen_t'(cnt) + mlen_t'(wr_go);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr     <= '0;
            in_pkt <= 1'b0;
            cnt    <= '0;
            base   <= '0;
        end else begin
            wr.en   <= wr_go;
            wr.addr <= base + mlen_t'(cnt);
            wr.data <= pld_data;
            unique case (verdict)
                HV_START: begin
                    in_pkt <= 1'b1;
                    cnt    <= '0;
                    base   <= '0;
                end
                HV_NEXT: begin
                    in_pkt <= 1'b1;
                    cnt    <= '0;
                end
                HV_ERR_SEQ: in_pkt <= 1'b0;
                HV_ERR_TOT: in_pkt <= 1'b0;
                default: begin
                    if (wr_go)
                        cnt <= cnt + pcnt_t'(1);
                    if (ovf_abort) begin
                        in_pkt <= 1'b0;
                    end else if (pkt_close) begin
                        in_pkt <= 1'b0;
                        base   <= close_len;
                    end
                end
            endcase
        end
    end

    // R8: the per-packet byte count never passes the payload limit
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= pcnt_t'(MAX_PLD));

    // R8: after an overflow no packet stays open
    a_r8_ovf_stops: assert property (@(posedge clk) disable iff (rst)
        ovf_abort |=> !in_pkt);

    // R10: with no packet open and no header, nothing is written next cycle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!in_pkt && hdr_idle) |=> !wr.en);

    // R12: every write lands inside the largest message
    a_r12_addr_range: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (wr.addr < mlen_t'(MAX_MSG)));

endmodule

// File: rtl/msg_rasm_evt.sv
module msg_rasm_evt
    import msg_rasm_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  hdr_verdict_e verdict,
    input  logic         ovf_abort,
    input  logic         pkt_close,
    input  logic         last_pkt,
    input  mlen_t        close_len,
    output evt_t         evt,
    output mlen_t        len
);

    always_ff @(posedge clk) begin
        if (rst) begin
            evt <= '0;
            len <= '0;
        end else begin
            evt.done <= pkt_close && last_pkt;
            evt.seq  <= (verdict == HV_ERR_SEQ);
            evt.tot  <= (verdict == HV_ERR_TOT);
            evt.ovf  <= ovf_abort;
            if (pkt_close && last_pkt)
                len <= close_len;
        end
    end

    // R11: completion and the three faults exclude one another
    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.done, evt.seq, evt.tot, evt.ovf}));

    // R11: a completion is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        evt.done |=> !evt.done);

    // R4: a reported length never exceeds the largest message
    a_r4_len_bound: assert property (@(posedge clk) disable iff (rst)
        evt.done |-> (len <= mlen_t'(MAX_MSG)));

endmodule

// File: rtl/msg_reassembler.sv
module msg_reassembler
    import msg_rasm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hdr_valid,
    input  logic [NUM_W-1:0] hdr_total,
    input  logic [NUM_W-1:0] hdr_num,
    input  logic             pld_valid,
    input  logic [BYTE_W-1:0] pld_data,
    input  logic             pkt_end,
    output logic             wr_en,
    output logic [MSG_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic             msg_done,
    output logic [MSG_W-1:0] msg_len,
    output logic             err_seq,
    output logic             err_total,
    output logic             err_ovf
);

    hdr_verdict_e verdict;
    logic         last_pkt;
    logic         pkt_close;
    logic         ovf_abort;
    mlen_t        close_len;
    wr_beat_t     wr;
    evt_t         evt;
    mlen_t        len;

    msg_rasm_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .hdr_valid (hdr_valid),
        .hdr_total (hdr_total),
        .hdr_num   (hdr_num),
        .pkt_close (pkt_close),
        .ovf_abort (ovf_abort),
        .verdict   (verdict),
        .last_pkt  (last_pkt)
    );

    msg_rasm_wr u_wr (
        .clk       (clk),
        .rst       (rst),
        .verdict   (verdict),
        .pld_valid (pld_valid),
        .pld_data  (pld_data),
        .pkt_end   (pkt_end),
        .wr        (wr),
        .ovf_abort (ovf_abort),
        .pkt_close (pkt_close),
        .close_len (close_len)
    );

    msg_rasm_evt u_evt (
        .clk       (clk),
        .rst       (rst),
        .verdict   (verdict),
        .ovf_abort (ovf_abort),
        .pkt_close (pkt_close),
        .last_pkt  (last_pkt),
        .close_len (close_len),
        .evt       (evt),
        .len       (len)
    );

    always_comb begin
        wr_en     = wr.en;
        wr_addr   = wr.addr;
        wr_data   = wr.data;
        msg_done  = evt.done;
        msg_len   = len;
        err_seq   = evt.seq;
        err_total = evt.tot;
        err_ovf   = evt.ovf;
    end

    // R1: the cycle after reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !(wr_en || msg_done || err_seq || err_total || err_ovf));

endmodule

// File: tb/msg_reassembler_bench.sv
module msg_reassembler_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hdr_valid = 1'b0;
    logic [7:0]  hdr_total = '0;
    logic [7:0]  hdr_num = '0;
    logic        pld_valid = 1'b0;
    logic [7:0]  pld_data = '0;
    logic        pkt_end = 1'b0;
    logic        wr_en;
    logic [14:0] wr_addr;
    logic [7:0]  wr_data;
    logic        msg_done;
    logic [14:0] msg_len;
    logic        err_seq;
    logic        err_total;
    logic        err_ovf;

    msg_reassembler u_msg_reassembler (
        .clk(clk), .rst(rst),
        .hdr_valid(hdr_valid), .hdr_total(hdr_total), .hdr_num(hdr_num),
        .pld_valid(pld_valid), .pld_data(pld_data), .pkt_end(pkt_end),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .msg_done(msg_done), .msg_len(msg_len),
        .err_seq(err_seq), .err_total(err_total), .err_ovf(err_ovf)
    );

    always #10 clk = ~clk;

    typedef struct { int addr; int data; string tag; } wr_item_t;
    typedef struct { int kind; int len; string tag; } ev_item_t;
    // kinds: 1 done, 2 sequence, 3 total, 4 overflow

    wr_item_t wq[$];
    ev_item_t eq[$];
    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    bit  m_act = 0, m_inpkt = 0;
    int  m_tot = 0, m_cur = 0, m_base = 0, m_cnt = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push_ev(input int kind, input int len, input string tag);
        ev_item_t e;
        e.kind = kind; e.len = len; e.tag = tag;
        eq.push_back(e);
    endtask

    task automatic m_hdr(input int tot, input int num, input string tag);
        if (num == 1 && tot != 0) begin
            m_act = 1; m_tot = tot; m_cur = 1; m_base = 0; m_inpkt = 1; m_cnt = 0;
        end else if (num == 1) begin
            push_ev(3, 0, tag); m_act = 0; m_inpkt = 0;
        end else if (!m_act || num != m_cur + 1) begin
            push_ev(2, 0, tag); m_act = 0; m_inpkt = 0;
        end else if (tot != m_tot) begin
            push_ev(3, 0, tag); m_act = 0; m_inpkt = 0;
        end else begin
            m_cur = num; m_inpkt = 1; m_cnt = 0;
        end
    endtask

    task automatic m_byte(input int d, input string tag);
        wr_item_t w;
        if (m_inpkt) begin
            if (m_cnt == 80) begin
                push_ev(4, 0, tag); m_inpkt = 0; m_act = 0;
            end else begin
                w.addr = m_base + m_cnt; w.data = d; w.tag = tag;
                wq.push_back(w);
                m_cnt++;
            end
        end
    endtask

    task automatic m_end(input string tag);
        if (m_inpkt) begin
            m_inpkt = 0;
            m_base  = m_base + m_cnt;
            if (m_cur == m_tot) begin
                push_ev(1, m_base, tag); m_act = 0;
            end
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic send_pkt(input int tot, input int num, input int nb,
                            input bit joint, input string tag);
        hdr_valid = 1; hdr_total = 8'(tot); hdr_num = 8'(num);
        m_hdr(tot, num, tag);
        tick();
        hdr_valid = 0;
        for (int i = 0; i < nb; i++) begin
            pld_valid = 1;
            pld_data  = 8'((num * 37 + i * 11 + tot) & 255);
            pkt_end   = joint && (i == nb - 1);
            m_byte(int'(pld_data), tag);
            if (pkt_end) m_end(tag);
            tick();
        end
        pld_valid = 0; pkt_end = 0;
        if (!joint || nb == 0) begin
            pkt_end = 1; m_end(tag); tick(); pkt_end = 0;
        end
    endtask

    task automatic send_stray(input int nb, input string tag);
        for (int i = 0; i < nb; i++) begin
            pld_valid = 1; pld_data = 8'(i + 200);
            pkt_end = (i == nb - 1);
            m_byte(int'(pld_data), tag);
            if (pkt_end) m_end(tag);
            tick();
        end
        pld_valid = 0; pkt_end = 0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !finished) begin
            int nev;
            nev = int'(msg_done) + int'(err_seq) + int'(err_total) + int'(err_ovf);
            if (nev > 1) chk(0, "R11", "simultaneous events", nev, 1);
            if (wr_en) begin
                if (wq.size() == 0) chk(0, "R10", "unexpected write addr", int'(wr_addr), -1);
                else begin
                    wr_item_t w;
                    w = wq.pop_front();
                    chk(int'(wr_addr) == w.addr, w.tag, "write addr", int'(wr_addr), w.addr);
                    chk(int'(wr_data) == w.data, w.tag, "write data", int'(wr_data), w.data);
                end
            end
            if (nev == 1) begin
                int k;
                k = msg_done ? 1 : err_seq ? 2 : err_total ? 3 : 4;
                if (eq.size() == 0) chk(0, "R10", "unexpected event kind", k, 0);
                else begin
                    ev_item_t e;
                    e = eq.pop_front();
                    chk(k == e.kind, e.tag, "event kind", k, e.kind);
                    if (e.kind == 1)
                        chk(int'(msg_len) == e.len, e.tag, "message length", int'(msg_len), e.len);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "WD", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!(wr_en | msg_done | err_seq | err_total | err_ovf), "R1", "outputs in reset",
            int'({wr_en, msg_done, err_seq, err_total, err_ovf}), 0);
        @(posedge clk); #1; rst = 0;
        @(negedge clk);
        chk(!(wr_en | msg_done | err_seq | err_total | err_ovf), "R1", "outputs after reset",
            int'({wr_en, msg_done, err_seq, err_total, err_ovf}), 0);
        tick();

        // R2 R4: single packet message
        send_pkt(1, 1, 5, 0, "R2");
        tick(); tick();
        // R3 R5: three packets, empty middle one, joint end on the last
        send_pkt(3, 1, 10, 0, "R3");
        send_pkt(3, 2, 0, 0, "R5");
        send_pkt(3, 3, 7, 1, "R4");
        tick();
        // R5: empty single packet message, length 0
        send_pkt(1, 1, 0, 0, "R5");
        // R6: skipped number, then orphan packet
        send_pkt(3, 1, 4, 0, "R6");
        send_pkt(3, 3, 4, 0, "R6");
        send_pkt(3, 2, 4, 0, "R6");
        // R6: repeated number, then number 0
        send_pkt(4, 1, 2, 0, "R6");
        send_pkt(4, 2, 2, 0, "R6");
        send_pkt(4, 2, 2, 0, "R6");
        send_pkt(4, 0, 1, 0, "R6");
        // R7: total mismatch and zero total
        send_pkt(4, 1, 3, 0, "R7");
        send_pkt(5, 2, 3, 0, "R7");
        send_pkt(0, 1, 3, 0, "R7");
        // R8: exactly 80 bytes, then 81 with end in the overflow cycle
        send_pkt(1, 1, 80, 1, "R8");
        send_pkt(2, 1, 81, 1, "R8");
        send_pkt(2, 2, 3, 0, "R8");
        // R9: restart mid message
        send_pkt(3, 1, 6, 0, "R9");
        send_pkt(3, 2, 4, 0, "R9");
        send_pkt(2, 1, 3, 0, "R9");
        send_pkt(2, 2, 2, 1, "R9");
        // R10: stray bytes and end markers with no packet open
        send_stray(4, "R10");
        send_stray(1, "R10");
        // R12: largest message
        for (int p = 1; p <= 255; p++) send_pkt(255, p, 80, 1, "R12");
        repeat (5) tick();
        chk(wq.size() == 0, "R2", "pending writes", wq.size(), 0);
        chk(eq.size() == 0, "R4", "pending events", eq.size(), 0);
        finish_run();
    end

endmodule